// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers 96 interrupt sources into one level-sensitive CPU interrupt line. It also gives a vector register that names the lowest-numbered source that is both pending and enabled. Two 32-bit main cause words arrive as live level inputs from other units. A third group of 32 general-purpose-port events is latched in a sticky port cause register inside the block. Software clears that register by writing zeros to the bits it wants gone.

The port group reaches the main high word through four summary bits. Each summary bit is the OR of one byte of the port cause register. When the search of the main high word lands on a summary bit, a second search runs over the enabled port cause bits and gives the vector. Each main word passes through a fixed valid-bit filter before the search, so unused positions can never win. When no source qualifies, the vector reads a reserved bogus code and its valid flag is clear.

Software reaches everything through a small word-addressed register port. The port has a single-cycle write strobe and a combinational read.

Top module: `casc_irq_ctrl`

## Requirements
- R1: Source numbers are fixed: main low bit i is source i, main high bit i is source 32+i, and port cause bit i is source 64+i. The vector register (offset 0x18) returns the source number in bits 6:0 and a valid flag in bit 31, with all other bits zero.
- R2: Enabled, qualifying main low sources always win over main high and port sources.
- R3: Before the search, main low is ANDed with 0x3dfffffe and main high with 0x0f000db7. A set bit outside these constants never produces a vector, even when it is enabled.
- R4: Main high bit 24+k reads as the OR of port cause bits 8k to 8k+7, for k = 0 to 3. It reads this way at offset 0x4, and it takes part in the search the same way.
- R5: When the lowest qualifying main high bit is 24 or above, the vector is 64 plus the lowest port cause bit that is set and enabled in the port mask. A qualifying main high bit below 24 gives 32 plus its index.
- R6: When nothing qualifies, or a summary bit wins but no enabled port bit is pending, the vector reads code 0x7F with the valid flag at 0.
- R7: A write to the port cause register (offset 0x10) clears each cause bit whose write-data bit is 0 and leaves bits at 1 unchanged. A port event pulse sets its cause bit on the next clock.
- R8: A port event and a clearing write to the same bit in the same cycle leave that bit set.
- R9: The masks sit at offsets 0x8 (low), 0xC (high) and 0x14 (port); a set bit enables its source. After reset the low mask and port mask are zero and the high mask is 0x0f000000. The port cause register is also zero after reset.
- R10: irq_out is high exactly when the vector valid flag is 1. It follows changes of the cause inputs in the same cycle, with no register in the path.
- R11: Writes to the read-only offsets 0x0, 0x4 and 0x18 have no effect. Offsets 0x0 and 0x4 return the live main cause inputs, and any offset outside the map reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| main_lo_src | input | 32 | Live main low cause word |
| main_hi_src | input | 32 | Live main high cause word (bits 27:24 are replaced by port summaries) |
| port_evt | input | 32 | One-cycle event pulses that set port cause bits |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Level CPU interrupt request |

## Verification
The assertions assume the main cause inputs and port events change only between clock edges, and that every access uses a word-aligned offset. The bench drives all inputs on the falling edge and uses only aligned offsets from the map. The port-clear property assumes no event pulse lands in the same cycle, so the bench keeps write-only clears apart from the one collision scenario, which targets R8 on purpose. Summary bits are never driven as raw main-high inputs with meaning, because the block overrides them; the bench drives them to 1 once to show that they are overridden.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

    localparam int WORD_W    = 32;
    localparam int IDX_W     = $clog2(WORD_W);
    localparam int VEC_W     = 7;
    localparam int SUM_CNT   = 4;
    localparam int SUM_LSB   = 24;
    localparam int GRP_W     = WORD_W / SUM_CNT;
    localparam int HI_BASE   = 32;
    localparam int PORT_BASE = 64;

    localparam logic [WORD_W-1:0] LO_QUAL     = 32'h3dff_fffe;
    localparam logic [WORD_W-1:0] HI_QUAL     = 32'h0f00_0db7;
    localparam logic [WORD_W-1:0] HI_MASK_RST = 32'h0f00_0000;
    localparam logic [VEC_W-1:0]  BOGUS_CODE  = 7'h7F;

    typedef enum logic [2:0] {
        SEL_LO_CAUSE  = 3'd0,
        SEL_HI_CAUSE  = 3'd1,
        SEL_LO_MASK   = 3'd2,
        SEL_HI_MASK   = 3'd3,
        SEL_PORT_CAUSE= 3'd4,
        SEL_PORT_MASK = 3'd5,
        SEL_VECTOR    = 3'd6,
        SEL_NONE      = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } find_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] code;
    } vec_t;

    // lowest set bit, scanned downward so the last hit is the smallest index
    function automatic find_t lowest_set(input logic [WORD_W-1:0] v);
        find_t r;
        r = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = i[IDX_W-1:0];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_port_cause.sv
module irq_port_cause
    import casc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] evt,
    input  logic              clr_wr,
    input  logic [WORD_W-1:0] clr_data,
    output logic [WORD_W-1:0] cause,
    output logic [SUM_CNT-1:0] summary
);

    logic [WORD_W-1:0] keep;

    // zero bits in the write data drop the cause bit, events override
    assign keep = clr_wr ? clr_data : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= '0;
        end else begin
            cause <= (cause & keep) | evt;
        end
    end

    for (genvar k = 0; k < SUM_CNT; k++) begin : g_sum
        assign summary[k] = |cause[k*GRP_W +: GRP_W];
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import casc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] lo_mask,
    output logic [WORD_W-1:0] hi_mask,
    output logic [WORD_W-1:0] port_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_mask   <= '0;
            hi_mask   <= HI_MASK_RST;
            port_mask <= '0;
        end else if (wr) begin
            case (sel)
                SEL_LO_MASK:   lo_mask   <= wdata;
                SEL_HI_MASK:   hi_mask   <= wdata;
                SEL_PORT_MASK: port_mask <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_cascade_resolve.sv
module irq_cascade_resolve
    import casc_irq_pkg::*;
(
    input  logic [WORD_W-1:0] lo_cause,
    input  logic [WORD_W-1:0] hi_cause,
    input  logic [WORD_W-1:0] port_cause,
    input  logic [WORD_W-1:0] lo_mask,
    input  logic [WORD_W-1:0] hi_mask,
    input  logic [WORD_W-1:0] port_mask,
    output vec_t              vec
);

    find_t lo_f, hi_f, port_f;

    always_comb begin
        lo_f   = lowest_set(lo_cause & LO_QUAL & lo_mask);
        hi_f   = lowest_set(hi_cause & HI_QUAL & hi_mask);
        port_f = lowest_set(port_cause & port_mask);

        vec.valid = 1'b0;
        vec.code  = BOGUS_CODE;
        if (lo_f.hit) begin
            vec.valid = 1'b1;
            vec.code  = VEC_W'(lo_f.idx);
        end else if (hi_f.hit) begin
            if (int'(hi_f.idx) >= SUM_LSB) begin
                if (port_f.hit) begin
                    vec.valid = 1'b1;
                    vec.code  = VEC_W'(PORT_BASE + int'(port_f.idx));
                end
            end else begin
                vec.valid = 1'b1;
                vec.code  = VEC_W'(HI_BASE + int'(hi_f.idx));
            end
        end
    end

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import casc_irq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       main_lo_src,
    input  logic [31:0]       main_hi_src,
    input  logic [31:0]       port_evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);

    reg_sel_e           sel;
    logic [WORD_W-1:0]  lo_mask, hi_mask, port_mask, port_cause;
    logic [SUM_CNT-1:0] summary;
    logic [WORD_W-1:0]  hi_eff;
    vec_t               vec;
    logic               vec_valid;
    logic [VEC_W-1:0]   vec_code;

    always_comb begin
        if (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:2] > 3'd6) begin
            sel = SEL_NONE;
        end else begin
            sel = reg_sel_e'(bus_addr[4:2]);
        end
    end

    irq_port_cause u_port (
        .clk      (clk),
        .rst      (rst),
        .evt      (port_evt),
        .clr_wr   (bus_wr && sel == SEL_PORT_CAUSE),
        .clr_data (bus_wdata),
        .cause    (port_cause),
        .summary  (summary)
    );

    irq_mask_bank u_mask (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .lo_mask   (lo_mask),
        .hi_mask   (hi_mask),
        .port_mask (port_mask)
    );

    always_comb begin
        hi_eff = main_hi_src;
        hi_eff[SUM_LSB +: SUM_CNT] = summary;
    end

    irq_cascade_resolve u_res (
        .lo_cause   (main_lo_src),
        .hi_cause   (hi_eff),
        .port_cause (port_cause),
        .lo_mask    (lo_mask),
        .hi_mask    (hi_mask),
        .port_mask  (port_mask),
        .vec        (vec)
    );

    assign vec_valid = vec.valid;
    assign vec_code  = vec.code;
    assign irq_out   = vec_valid;

    always_comb begin
        case (sel)
            SEL_LO_CAUSE:   bus_rdata = main_lo_src;
            SEL_HI_CAUSE:   bus_rdata = hi_eff;
            SEL_LO_MASK:    bus_rdata = lo_mask;
            SEL_HI_MASK:    bus_rdata = hi_mask;
            SEL_PORT_CAUSE: bus_rdata = port_cause;
            SEL_PORT_MASK:  bus_rdata = port_mask;
            SEL_VECTOR:     bus_rdata = {vec_valid, {(WORD_W-1-VEC_W){1'b0}}, vec_code};
            default:        bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk
    import casc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [31:0]       main_lo_src,
    input logic [31:0]       port_evt,
    input logic              bus_wr,
    input logic [4:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_out,
    input logic [31:0]       lo_mask,
    input logic [31:0]       hi_mask,
    input logic [31:0]       port_mask,
    input logic [31:0]       port_cause,
    input logic              vec_valid,
    input logic [6:0]        vec_code
);

    // R6
    bogus_code_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> vec_code == BOGUS_CODE);

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == vec_valid);

    // R2
    low_first_chk: assert property (@(posedge clk) disable iff (rst)
        (|(main_lo_src & LO_QUAL & lo_mask)) |-> (vec_valid && vec_code < 7'd32));

    // R3
    qual_only_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_code < 7'd32) |-> LO_QUAL[vec_code[4:0]]);

    // R5
    port_win_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_code >= 7'd64) |->
            (port_cause[vec_code[4:0]] && port_mask[vec_code[4:0]]));

    // R8
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (port_evt != '0) |=> ((port_cause & $past(port_evt)) == $past(port_evt)));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h10 && port_evt == '0) |=>
            port_cause == ($past(port_cause) & $past(bus_wdata)));

    // R9
    mask_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> (lo_mask == '0 && port_mask == '0 && hi_mask == HI_MASK_RST
                        && port_cause == '0));

endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .main_lo_src (main_lo_src),
    .port_evt    (port_evt),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq_out     (irq_out),
    .lo_mask     (lo_mask),
    .hi_mask     (hi_mask),
    .port_mask   (port_mask),
    .port_cause  (port_cause),
    .vec_valid   (vec_valid),
    .vec_code    (vec_code)
);

// File: tb/casc_irq_ctrl_tb_top.sv
module casc_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BOGUS_RD = 32'h0000_007F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] main_lo_src = '0;
    logic [31:0] main_hi_src = '0;
    logic [31:0] port_evt = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_irq_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .main_lo_src (main_lo_src),
        .main_hi_src (main_hi_src),
        .port_evt    (port_evt),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_out     (irq_out)
    );

    function automatic logic [31:0] vec_of(input int n);
        return {1'b1, 24'd0, 7'(n)};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        port_evt = e;
        @(negedge clk);
        port_evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h08, d); check("R9 lo mask", d, 32'h0);
        rd(5'h0C, d); check("R9 hi mask", d, 32'h0f00_0000);
        rd(5'h14, d); check("R9 port mask", d, 32'h0);
        rd(5'h10, d); check("R9 port cause", d, 32'h0);
        rd(5'h18, d); check("R6 vector idle", d, BOGUS_RD);
        check("R10 irq idle", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_low();
        logic [31:0] d;
        wr(5'h08, 32'hFFFF_FFFF);
        main_lo_src = 32'h0000_0104;
        rd(5'h18, d); check("R1 low vector 2", d, vec_of(2));
        check("R10 irq high", {31'd0, irq_out}, 32'd1);
        main_lo_src = 32'h0000_0001;
        rd(5'h18, d); check("R3 bit0 filtered", d, BOGUS_RD);
        check("R10 irq follows", {31'd0, irq_out}, 32'd0);
        main_lo_src = 32'h4200_0000;
        rd(5'h18, d); check("R3 bits30/25 filtered", d, BOGUS_RD);
        main_lo_src = 32'h2000_0000;
        rd(5'h18, d); check("R1 low vector 29", d, vec_of(29));
        wr(5'h08, 32'hDFFF_FFFF);
        rd(5'h18, d); check("R9 masked low", d, BOGUS_RD);
        main_lo_src = '0;
        wr(5'h08, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        main_lo_src = 32'h0000_0020;
        main_hi_src = 32'h0000_0001;
        rd(5'h18, d); check("R2 low beats high", d, vec_of(5));
        main_lo_src = '0;
        rd(5'h18, d); check("R5 high vector 32", d, vec_of(32));
        main_hi_src = 32'h0000_0008;
        rd(5'h18, d); check("R3 high bit3 filtered", d, BOGUS_RD);
        main_hi_src = 32'h0000_0810;
        rd(5'h18, d); check("R5 high vector 36", d, vec_of(36));
        main_hi_src = '0;
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h0f00_0000);
    endtask

    task automatic t_cascade();
        logic [31:0] d;
        main_hi_src = 32'h0F00_0000;
        rd(5'h04, d); check("R4 raw summary overridden", d, 32'h0);
        pulse(32'h0000_0200);
        rd(5'h10, d); check("R7 event latched", d, 32'h0000_0200);
        rd(5'h04, d); check("R4 summary bit 25", d, 32'h0200_0000);
        rd(5'h18, d); check("R6 summary no port", d, BOGUS_RD);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h18, d); check("R5 port vector 73", d, vec_of(73));
        pulse(32'h0010_0000);
        rd(5'h18, d); check("R5 lowest port kept", d, vec_of(73));
        rd(5'h04, d); check("R4 two summaries", d, 32'h0600_0000);
        wr(5'h10, ~32'h0000_0200);
        rd(5'h10, d); check("R7 zero clears", d, 32'h0010_0000);
        rd(5'h18, d); check("R5 port vector 84", d, vec_of(84));
        main_hi_src = 32'h0000_0004;
        wr(5'h0C, 32'h0f00_0004);
        rd(5'h18, d); check("R5 high below summary", d, vec_of(34));
        main_hi_src = '0;
        wr(5'h0C, 32'h0f00_0000);
        wr(5'h10, 32'h0);
        rd(5'h10, d); check("R7 clear all", d, 32'h0);
        check("R10 irq drops", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(32'h0000_0028);
        @(negedge clk);
        port_evt = 32'h0000_0008;
        bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h0;
        @(negedge clk);
        port_evt = '0; bus_wr = 1'b0;
        rd(5'h10, d); check("R8 event beats clear", d, 32'h0000_0008);
        wr(5'h10, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        main_lo_src = 32'hA5A5_0F0F;
        wr(5'h00, 32'h0);
        rd(5'h00, d); check("R11 low cause live", d, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h08, d); check("R11 no side write lo", d, 32'h0);
        rd(5'h0C, d); check("R11 no side write hi", d, 32'h0f00_0000);
        rd(5'h14, d); check("R11 no side write port", d, 32'hFFFF_FFFF);
        rd(5'h10, d); check("R11 cause untouched", d, 32'h0);
        rd(5'h1C, d); check("R11 unmapped reads zero", d, 32'h0);
        main_lo_src = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_low();
        t_prio();
        t_cascade();
        t_collide();
        t_readonly();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule